// File: doc/BRIEF.md
# Memory-Unit Command Responder

This block answers the commands a host sends to the storage sub-unit of a peripheral. A receiver upstream has already taken the frame apart. It gives this block the command code, the source and destination addresses, the payload length in 32-bit words and a flag that marks a damaged frame. The payload words follow one per cycle. The block decodes the request and builds the reply, which is a header (command, length, echoed addresses) followed by the payload words one per cycle, ready for a transmitter.

Storage is an internal word RAM that holds `NUM_BLOCKS` blocks of 512 bytes each. A full unit uses 128 blocks, and the default is kept small. A read returns a whole block in one reply. A write carries one quarter of a block, and a phase number picks which quarter. Four writes therefore fill a block. Identity, condition and media queries return fixed words that are set by parameters. A write whose length is not the expected 34 words raises an error flag that stays set.

Top module: `mem_unit_responder`

## Requirements
- R1: After reset, `rspValid`, `outValid`, `busy` and `lenError` are all low.
- R2: A request gets a reply only when bits 5:0 of its destination equal 0x01. Bits 7:6 are ignored. Any other destination, 0x20 included, gets no reply.
- R3: Command 0x01 (identity) replies with command 0x05 and length 28. Word 0 is the function ID, word 1 is the descriptor word and word 27 is the power word. All other words are zero. The reply source and destination equal the request's source and destination.
- R4: Commands 0x09 (condition) and 0x0A (media info) both reply with command 0x08 and length 7. Word 0 is the function ID. Words 1 to 6 are the 192-bit media parameter, most significant word first.
- R5: Command 0x0B (block read) replies with command 0x08 and length 130. Word 0 is the function ID and word 1 echoes the request's location word. Words 2 to 129 are the 128 stored words of the block named by location bits 7:0. The phase bits 23:16 are ignored on a read. A block number of `NUM_BLOCKS` or more returns zero data words.
- R6: Command 0x0C (block write) carries word 0 = function ID and word 1 = location (phase in bits 23:16, block in bits 7:0). Words 2 to 33 are stored at word offset block·128 + phase·32 + k. The reply is command 0x07 with length 0.
- R7: A block write is acknowledged but stores nothing if any of these hold: the frame was flagged bad, word 0 differs from the function ID, the phase is 4 or more, or the block is out of range.
- R8: A block write whose length is not 34 sets `lenError`, which stays high until reset. The write is still acknowledged.
- R9: Command 0x0D (write complete) replies with command 0x07 and length 0, with no payload words.
- R10: An unknown command gives no reply. Its payload words are still consumed, so the next request is decoded correctly.
- R11: For a request with L payload words whose `reqValid` is sampled at edge E0, `rspValid` is high for exactly one cycle after edge E(L+1). Payload word i is valid after edge E(L+2+i), with no gaps, and never in the same cycle as `rspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request header present (accepted only when `busy` is low) |
| reqCmd | input | 8 | Request command code |
| reqSrc | input | 8 | Request source address |
| reqDst | input | 8 | Request destination address |
| reqLen | input | 8 | Request payload length in words |
| reqBadFrame | input | 1 | The received frame was damaged |
| inValid | input | 1 | Request payload word present |
| inWord | input | 32 | Request payload word |
| rspValid | output | 1 | Response header strobe, one cycle |
| rspCmd | output | 8 | Response command code |
| rspSrc | output | 8 | Response source (echo of request) |
| rspDst | output | 8 | Response destination (echo of request) |
| rspLen | output | 8 | Response payload length in words |
| outValid | output | 1 | Response payload word present |
| outWord | output | 32 | Response payload word |
| busy | output | 1 | A request is being taken or answered |
| lenError | output | 1 | Sticky flag: a block write had the wrong length |

## Verification
The reply header is due L+1 edges after the request header, where L is the payload length. Payload word i follows at L+2+i edges. The bench drives the request on falling edges, one word per cycle. It then samples `rspValid` on the exact falling edge where it is due, and counts a header that is early or late as a failure. It then reads one word per falling edge and flags any gap in `outValid`. For requests that should get no reply, the bench watches both output strobes over a window longer than the reply delay. Stored data is checked by reading it back through block-read replies and comparing against a model in the bench.

// File: rtl/mu_pkg.sv
`timescale 1ns/1ps
package mu_pkg;

  localparam logic [7:0] OP_WHO     = 8'h01;
  localparam logic [7:0] OP_WHO_RSP = 8'h05;
  localparam logic [7:0] OP_ACK     = 8'h07;
  localparam logic [7:0] OP_DATA    = 8'h08;
  localparam logic [7:0] OP_STATUS  = 8'h09;
  localparam logic [7:0] OP_MEDIA   = 8'h0A;
  localparam logic [7:0] OP_RD      = 8'h0B;
  localparam logic [7:0] OP_WR      = 8'h0C;
  localparam logic [7:0] OP_WEND    = 8'h0D;

  localparam logic [7:0] WHO_LEN    = 8'd28;
  localparam logic [7:0] MEDIA_LEN  = 8'd7;

  typedef enum logic [2:0] {K_NONE, K_IDENT, K_MEDIA, K_READ, K_WRITE, K_DONE} kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       hdrLoad;
    logic       wordTake;
    logic       hdrSend;
    logic       wordSend;
    logic [7:0] idx;
    kind_e      kind;
  } strobe_t;

  function automatic kind_e decodeKind(input logic [7:0] cmd, input logic hit);
    kind_e k;
    k = K_NONE;
    if (hit) begin
      case (cmd)
        OP_WHO:              k = K_IDENT;
        OP_STATUS, OP_MEDIA: k = K_MEDIA;
        OP_RD:               k = K_READ;
        OP_WR:               k = K_WRITE;
        OP_WEND:             k = K_DONE;
        default:             k = K_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic [7:0] rspLenOf(input kind_e k, input logic [7:0] readLen);
    case (k)
      K_IDENT: return WHO_LEN;
      K_MEDIA: return MEDIA_LEN;
      K_READ:  return readLen;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] rspCmdOf(input kind_e k);
    case (k)
      K_IDENT:         return OP_WHO_RSP;
      K_MEDIA, K_READ: return OP_DATA;
      K_WRITE, K_DONE: return OP_ACK;
      default:         return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mu_ctrl.sv
`timescale 1ns/1ps
module mu_ctrl
  import mu_pkg::*;
#(
  parameter logic [5:0] SUB_ADDR = 6'h01,
  parameter logic [7:0] READ_LEN = 8'd130
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [7:0] reqCmd,
  input  logic [5:0] dstSub,
  input  logic [7:0] reqLen,
  input  logic       inValid,
  output strobe_t    stb,
  output logic       busy
);

  typedef enum logic [1:0] {S_IDLE, S_TAKE, S_HDR, S_SEND} st_e;

  st_e        st;
  kind_e      kindQ;
  logic [7:0] lenQ;
  logic [7:0] cnt;
  kind_e      kindDec;
  logic [7:0] outLen;

  assign kindDec = decodeKind(reqCmd, dstSub == SUB_ADDR);
  assign outLen  = rspLenOf(kindQ, READ_LEN);
  assign busy    = (st != S_IDLE);

  always_comb begin
    stb      = '0;
    stb.kind = (st == S_IDLE) ? kindDec : kindQ;
    stb.idx  = cnt;
    case (st)
      S_IDLE:  stb.hdrLoad  = reqValid;
      S_TAKE:  stb.wordTake = inValid;
      S_HDR:   stb.hdrSend  = 1'b1;
      default: stb.wordSend = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= S_IDLE;
      kindQ <= K_NONE;
      lenQ  <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (reqValid) begin
            kindQ <= kindDec;
            lenQ  <= reqLen;
            cnt   <= '0;
            if (reqLen != 8'd0)       st <= S_TAKE;
            else if (kindDec != K_NONE) st <= S_HDR;
          end
        end
        S_TAKE: begin
          if (inValid) begin
            if (cnt == lenQ - 8'd1) begin
              cnt <= '0;
              st  <= (kindQ != K_NONE) ? S_HDR : S_IDLE;
            end else begin
              cnt <= cnt + 8'd1;
            end
          end
        end
        S_HDR: begin
          cnt <= '0;
          st  <= (outLen != 8'd0) ? S_SEND : S_IDLE;
        end
        default: begin
          if (cnt == outLen - 8'd1) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 8'd1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mu_dpath.sv
`timescale 1ns/1ps
module mu_dpath
  import mu_pkg::*;
#(
  parameter int            NUM_BLOCKS  = 8,
  parameter int            BLOCK_WORDS = 128,
  parameter int            PHASES      = 4,
  parameter logic [31:0]   FUNC_ID     = 32'h0000_0002,
  parameter logic [31:0]   DESC_WORD   = 32'h0010_4000,
  parameter logic [31:0]   POWER_WORD  = 32'h0064_00C8,
  parameter logic [191:0]  MEDIA_INFO  = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [7:0]  reqSrc,
  input  logic [7:0]  reqDst,
  input  logic [7:0]  reqLen,
  input  logic        reqBadFrame,
  input  logic [31:0] inWord,
  output logic        rspValid,
  output logic [7:0]  rspCmd,
  output logic [7:0]  rspSrc,
  output logic [7:0]  rspDst,
  output logic [7:0]  rspLen,
  output logic        outValid,
  output logic [31:0] outWord,
  output logic        lenError
);

  localparam int         PHASE_WORDS = BLOCK_WORDS / PHASES;
  localparam int         DEPTH       = NUM_BLOCKS * BLOCK_WORDS;
  localparam int         AW          = $clog2(DEPTH);
  localparam int         MEDIA_WORDS = 6;
  localparam logic [7:0] WR_LEN      = 8'(PHASE_WORDS + 2);
  localparam logic [7:0] READ_LEN    = 8'(BLOCK_WORDS + 2);

  logic [7:0]  srcQ, dstQ;
  logic        badQ;
  logic [31:0] funcQ, locQ;
  logic        lenErrQ;
  logic [7:0]  blk, ph;
  logic        blkOk, wrOk, rdHit;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [31:0] mem [DEPTH];
  logic [31:0] memQ, wordQ, word;
  logic        selMemQ;

  assign blk   = locQ[7:0];
  assign ph    = locQ[23:16];
  assign blkOk = 32'(blk) < NUM_BLOCKS;

  assign wrOk  = stb.wordTake && (stb.kind == K_WRITE) && !badQ && (funcQ == FUNC_ID)
              && blkOk && (32'(ph) < PHASES)
              && (stb.idx >= 8'd2) && (32'(stb.idx) < PHASE_WORDS + 2);
  assign rdHit = stb.wordSend && (stb.kind == K_READ) && (stb.idx >= 8'd2) && blkOk;

  assign wrAddr = AW'(32'(blk) * BLOCK_WORDS + 32'(ph) * PHASE_WORDS + 32'(stb.idx) - 32'd2);
  assign rdAddr = AW'(32'(blk) * BLOCK_WORDS + 32'(stb.idx) - 32'd2);

  // block storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wrOk)  mem[wrAddr] <= inWord;
    if (rdHit) memQ <= mem[rdAddr];
  end

  // non-memory payload words
  always_comb begin
    word = '0;
    case (stb.kind)
      K_IDENT: begin
        if (stb.idx == 8'd0)                word = FUNC_ID;
        else if (stb.idx == 8'd1)           word = DESC_WORD;
        else if (stb.idx == WHO_LEN - 8'd1) word = POWER_WORD;
      end
      K_MEDIA: begin
        if (stb.idx == 8'd0) word = FUNC_ID;
        for (int k = 1; k <= MEDIA_WORDS; k++) begin
          if (32'(stb.idx) == k) word = MEDIA_INFO[(MEDIA_WORDS - k) * 32 +: 32];
        end
      end
      K_READ: begin
        if (stb.idx == 8'd0)      word = FUNC_ID;
        else if (stb.idx == 8'd1) word = locQ;
      end
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ     <= '0;
      dstQ     <= '0;
      badQ     <= 1'b0;
      funcQ    <= '0;
      locQ     <= '0;
      lenErrQ  <= 1'b0;
      rspValid <= 1'b0;
      rspCmd   <= '0;
      rspLen   <= '0;
      outValid <= 1'b0;
      wordQ    <= '0;
      selMemQ  <= 1'b0;
    end else begin
      if (stb.hdrLoad) begin
        srcQ  <= reqSrc;
        dstQ  <= reqDst;
        badQ  <= reqBadFrame;
        funcQ <= '0;
        locQ  <= '0;
        if (stb.kind == K_WRITE && reqLen != WR_LEN) lenErrQ <= 1'b1;
      end
      if (stb.wordTake) begin
        if (stb.idx == 8'd0) funcQ <= inWord;
        if (stb.idx == 8'd1) locQ  <= inWord;
      end
      rspValid <= stb.hdrSend;
      if (stb.hdrSend) begin
        rspCmd <= rspCmdOf(stb.kind);
        rspLen <= rspLenOf(stb.kind, READ_LEN);
      end
      outValid <= stb.wordSend;
      if (stb.wordSend) begin
        wordQ   <= word;
        selMemQ <= rdHit;
      end
    end
  end

  assign outWord  = selMemQ ? memQ : wordQ;
  assign rspSrc   = srcQ;
  assign rspDst   = dstQ;
  assign lenError = lenErrQ;

endmodule

// File: rtl/mem_unit_responder.sv
`timescale 1ns/1ps
module mem_unit_responder
  import mu_pkg::*;
#(
  parameter int           NUM_BLOCKS   = 8,
  parameter int           BLOCK_BYTES  = 512,
  parameter int           WRITE_PHASES = 4,
  parameter logic [5:0]   SUB_ADDR     = 6'h01,
  parameter logic [31:0]  FUNC_ID      = 32'h0000_0002,
  parameter logic [31:0]  DESC_WORD    = 32'h0010_4000,
  parameter logic [31:0]  POWER_WORD   = 32'h0064_00C8,
  parameter logic [191:0] MEDIA_INFO   = 192'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF_0102_0304_0506_0708
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [7:0]  reqCmd,
  input  logic [7:0]  reqSrc,
  input  logic [7:0]  reqDst,
  input  logic [7:0]  reqLen,
  input  logic        reqBadFrame,
  input  logic        inValid,
  input  logic [31:0] inWord,
  output logic        rspValid,
  output logic [7:0]  rspCmd,
  output logic [7:0]  rspSrc,
  output logic [7:0]  rspDst,
  output logic [7:0]  rspLen,
  output logic        outValid,
  output logic [31:0] outWord,
  output logic        busy,
  output logic        lenError
);

  localparam int         BLOCK_WORDS = BLOCK_BYTES / 4;
  localparam logic [7:0] READ_LEN    = 8'(BLOCK_WORDS + 2);

  strobe_t stb;

  mu_ctrl #(
    .SUB_ADDR (SUB_ADDR),
    .READ_LEN (READ_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqCmd   (reqCmd),
    .dstSub   (reqDst[5:0]),
    .reqLen   (reqLen),
    .inValid  (inValid),
    .stb      (stb),
    .busy     (busy)
  );

  mu_dpath #(
    .NUM_BLOCKS  (NUM_BLOCKS),
    .BLOCK_WORDS (BLOCK_WORDS),
    .PHASES      (WRITE_PHASES),
    .FUNC_ID     (FUNC_ID),
    .DESC_WORD   (DESC_WORD),
    .POWER_WORD  (POWER_WORD),
    .MEDIA_INFO  (MEDIA_INFO)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqSrc      (reqSrc),
    .reqDst      (reqDst),
    .reqLen      (reqLen),
    .reqBadFrame (reqBadFrame),
    .inWord      (inWord),
    .rspValid    (rspValid),
    .rspCmd      (rspCmd),
    .rspSrc      (rspSrc),
    .rspDst      (rspDst),
    .rspLen      (rspLen),
    .outValid    (outValid),
    .outWord     (outWord),
    .lenError    (lenError)
  );

endmodule

// File: rtl/mu_checker.sv
`timescale 1ns/1ps
module mu_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rspValid,
  input logic [7:0] rspCmd,
  input logic [7:0] rspLen,
  input logic       outValid,
  input logic       lenError
);

  // R3 R4 R6: only the three reply codes ever appear
  p_rsp_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCmd == 8'h05 || rspCmd == 8'h07 || rspCmd == 8'h08));

  // R9 R6: acknowledge carries no payload
  p_ack_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCmd == 8'h07) |-> (rspLen == 8'd0));

  // R4 R5: data replies always carry payload
  p_data_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCmd == 8'h08) |-> (rspLen != 8'd0));

  // R11: header and payload never share a cycle
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && outValid));

  // R11: first payload word directly follows the header
  p_first_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspLen != 8'd0) |=> outValid);

  // R9: an empty reply is followed by no payload
  p_empty_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspLen == 8'd0) |=> !outValid);

  // R8: error flag is sticky
  p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    lenError |=> lenError);

endmodule

bind mem_unit_responder mu_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rspValid (rspValid),
  .rspCmd   (rspCmd),
  .rspLen   (rspLen),
  .outValid (outValid),
  .lenError (lenError)
);

// File: tb/sim_mem_unit_responder.sv
`timescale 1ns/1ps
module sim_mem_unit_responder;

  localparam int             NB    = 8;
  localparam int             BW    = 128;
  localparam int             PW    = 32;
  localparam logic [31:0]    FID   = 32'h0000_0002;
  localparam logic [31:0]    DESC  = 32'h0010_4000;
  localparam logic [31:0]    PWR   = 32'h0064_00C8;
  localparam logic [191:0]   MINFO = 192'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF_0102_0304_0506_0708;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqCmd = '0, reqSrc = '0, reqDst = '0, reqLen = '0;
  logic        reqBadFrame = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        rspValid, outValid, busy, lenError;
  logic [7:0]  rspCmd, rspSrc, rspDst, rspLen;
  logic [31:0] outWord;

  always #2.5 clk = ~clk;

  mem_unit_responder #(
    .NUM_BLOCKS (NB), .BLOCK_BYTES (BW * 4), .WRITE_PHASES (4), .SUB_ADDR (6'h01),
    .FUNC_ID (FID), .DESC_WORD (DESC), .POWER_WORD (PWR), .MEDIA_INFO (MINFO)
  ) u0 (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqCmd (reqCmd), .reqSrc (reqSrc),
    .reqDst (reqDst), .reqLen (reqLen), .reqBadFrame (reqBadFrame), .inValid (inValid),
    .inWord (inWord), .rspValid (rspValid), .rspCmd (rspCmd), .rspSrc (rspSrc),
    .rspDst (rspDst), .rspLen (rspLen), .outValid (outValid), .outWord (outWord),
    .busy (busy), .lenError (lenError)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] model [NB*BW];
  logic [31:0] pay [64];
  logic [31:0] got [140];
  logic [7:0]  gCmd, gLen, gSrc, gDst;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expIdent(input int i);
    if (i == 0) return FID;
    if (i == 1) return DESC;
    if (i == 27) return PWR;
    return 32'h0;
  endfunction

  function automatic logic [31:0] expMedia(input int i);
    if (i == 0) return FID;
    return MINFO[(6 - i) * 32 +: 32];
  endfunction

  function automatic logic [31:0] expRead(input int blk, input logic [31:0] loc, input int i);
    if (i == 0) return FID;
    if (i == 1) return loc;
    if (blk < NB) return model[blk * BW + i - 2];
    return 32'h0;
  endfunction

  // drive one request; expect a reply or silence; capture the reply
  task automatic runReq(input logic [7:0] cmd, input logic [7:0] src, input logic [7:0] dst,
                        input int len, input bit badF, input bit expectRsp, input string req);
    bit seen;
    bit gap;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqSrc = src; reqDst = dst;
    reqLen = 8'(len); reqBadFrame = badF;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      reqValid = 1'b0; inValid = 1'b1; inWord = pay[j];
    end
    @(negedge clk);
    reqValid = 1'b0; inValid = 1'b0; inWord = '0;
    @(negedge clk);
    gLen = 8'd0; gCmd = 8'd0;
    if (expectRsp) begin
      chk({"R11 header due L+1 edges after request (", req, ")"}, 32'(rspValid), 32'd1);
      if (rspValid) begin
        gCmd = rspCmd; gLen = rspLen; gSrc = rspSrc; gDst = rspDst;
        gap = 1'b0;
        for (int i = 0; i < int'(gLen); i++) begin
          @(negedge clk);
          if (!outValid) gap = 1'b1;
          got[i] = outWord;
        end
        chk({"R11 payload words back to back (", req, ")"}, 32'(gap), 32'd0);
      end
    end else begin
      seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
        if (rspValid || outValid) seen = 1'b1;
        @(negedge clk);
      end
      chk({req, " no reply expected"}, 32'(seen), 32'd0);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doWrite(input int blk, input int ph, input logic [31:0] fid, input bit badF,
                         input int len, input bit commit, input string req);
    pay[0] = fid;
    pay[1] = {8'h00, 8'(ph), 8'h00, 8'(blk)};
    for (int k = 2; k < len; k++) pay[k] = $urandom;
    if (commit) begin
      for (int k = 0; k < PW; k++) model[blk * BW + ph * PW + k] = pay[k + 2];
    end
    runReq(8'h0C, 8'h00, 8'h01, len, badF, 1'b1, req);
    chk({req, " ack command"}, 32'(gCmd), 32'h07);
    chk({req, " ack length"}, 32'(gLen), 32'h0);
  endtask

  task automatic doRead(input int blk, input logic [31:0] loc, input string req);
    int mism;
    int first;
    pay[0] = FID;
    pay[1] = loc;
    runReq(8'h0B, 8'h00, 8'h01, 2, 1'b0, 1'b1, req);
    chk({req, " read command"}, 32'(gCmd), 32'h08);
    chk({req, " read length"}, 32'(gLen), 32'd130);
    mism = 0; first = -1;
    for (int i = 0; i < 130; i++) begin
      if (got[i] !== expRead(blk, loc, i)) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk({req, " read payload"}, 32'h0, 32'h0);
    else chk({req, " read payload first bad word"}, got[first], expRead(blk, loc, first));
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < NB * BW; i++) model[i] = 32'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rspValid after reset", 32'(rspValid), 32'd0);
    chk("R1 outValid after reset", 32'(outValid), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 lenError after reset", 32'(lenError), 32'd0);

    // R6: fill every block through four phase writes
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 4; p++)
        doWrite(b, p, FID, 1'b0, 34, 1'b1, "R6 fill");
    chk("R8 lenError low after good writes", 32'(lenError), 32'd0);

    // R5: read, then read with phase bits set
    doRead(3, 32'h0000_0003, "R5 block 3");
    doRead(5, 32'h0002_0005, "R5 phase bits ignored");
    doRead(9, 32'h0000_0009, "R5 out-of-range block zeros");

    // R3 with upper address bits set (R2)
    runReq(8'h01, 8'h20, 8'hC1, 0, 1'b0, 1'b1, "R2 R3 identity");
    chk("R3 identity command", 32'(gCmd), 32'h05);
    chk("R3 identity length", 32'(gLen), 32'd28);
    chk("R3 source echoed", 32'(gSrc), 32'h20);
    chk("R3 destination echoed", 32'(gDst), 32'hC1);
    begin
      int first = -1;
      for (int i = 0; i < 28; i++) if (first < 0 && got[i] !== expIdent(i)) first = i;
      if (first < 0) chk("R3 identity payload", 32'h0, 32'h0);
      else chk("R3 identity payload", got[first], expIdent(first));
    end

    // R4: condition and media queries
    for (int q = 0; q < 2; q++) begin
      int first = -1;
      pay[0] = FID;
      runReq(q == 0 ? 8'h09 : 8'h0A, 8'h00, 8'h01, 1, 1'b0, 1'b1, "R4 query");
      chk("R4 query command", 32'(gCmd), 32'h08);
      chk("R4 query length", 32'(gLen), 32'd7);
      for (int i = 0; i < 7; i++) if (first < 0 && got[i] !== expMedia(i)) first = i;
      if (first < 0) chk("R4 media payload", 32'h0, 32'h0);
      else chk("R4 media payload", got[first], expMedia(first));
    end

    // R2: wrong sub-address gets nothing
    runReq(8'h01, 8'h00, 8'h20, 0, 1'b0, 1'b0, "R2 main-unit address");
    runReq(8'h01, 8'h00, 8'h02, 0, 1'b0, 1'b0, "R2 other sub-address");

    // R10: unknown command with payload, then a good request still works
    pay[0] = 32'h1111_1111; pay[1] = 32'h2222_2222; pay[2] = 32'h3333_3333;
    runReq(8'h03, 8'h00, 8'h01, 3, 1'b0, 1'b0, "R10 unknown command");
    runReq(8'h0D, 8'h00, 8'h01, 0, 1'b0, 1'b1, "R10 R9 resync");
    chk("R9 write-complete ack", 32'(gCmd), 32'h07);
    chk("R9 write-complete length", 32'(gLen), 32'h0);

    // R7: dropped writes leave storage unchanged
    doWrite(1, 2, FID, 1'b1, 34, 1'b0, "R7 bad frame");
    doRead(1, 32'h0000_0001, "R7 bad frame dropped");
    doWrite(1, 1, 32'hDEAD_0000, 1'b0, 34, 1'b0, "R7 wrong function");
    doRead(1, 32'h0000_0001, "R7 wrong function dropped");
    doWrite(1, 4, FID, 1'b0, 34, 1'b0, "R7 phase 4");
    doRead(2, 32'h0000_0002, "R7 phase 4 dropped");
    doWrite(8, 0, FID, 1'b0, 34, 1'b0, "R7 block out of range");
    doRead(0, 32'h0000_0000, "R7 out of range dropped");
    chk("R8 lenError still low", 32'(lenError), 32'd0);

    // R8: long write still stores and acks, flag sticks
    doWrite(6, 3, FID, 1'b0, 36, 1'b1, "R8 long write");
    chk("R8 lenError set", 32'(lenError), 32'd1);
    doRead(6, 32'h0000_0006, "R8 long write stored");
    doWrite(6, 0, FID, 1'b0, 34, 1'b1, "R8 good write after");
    chk("R8 lenError stays set", 32'(lenError), 32'd1);

    // random mix of writes and read-backs
    for (int n = 0; n < 24; n++) begin
      int b = int'($urandom % NB);
      if ($urandom % 2 == 0) doWrite(b, int'($urandom % 4), FID, 1'b0, 34, 1'b1, "R6 random write");
      else doRead(b, {8'h00, 8'($urandom % 4), 8'h00, 8'(b)}, "R5 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule